// File: doc/BRIEF.md
# Configurable SPI Master/Slave Controller

This block is a byte-wide serial peripheral interface with two memory-mapped registers: a configuration register and a data register. One configuration bit selects master or slave operation. As a master it makes the serial clock from the system clock, using one of four fixed divide ratios, and starts a byte exchange whenever software writes the data register. As a slave it follows an external serial clock that is framed by an active-low select. The slave synchronises that clock, its select and its data input through a two-stage flip-flop chain before it detects edges.

Clock polarity, clock phase and bit order are each selectable. When a byte completes, a completion flag is set. A read of the data register clears the flag. The interrupt output is the flag gated by two enables: the local interrupt-enable bit and an external serial-interrupt enable input. The data register is a single shift register. A slave that is not reloaded therefore sends back the byte it last received.

The block has two resets. The cold reset clears everything. The warm reset clears the configuration, the flag and the sequencing state, but keeps the contents of the data register. While the enable bit is 0, every pin output enable is low.

Top module: `spi_port_ctrl`

## Requirements
- R1: After a cold reset, the configuration register and the data register read 0x00. The completion flag and the interrupt are low, and all three pin output enables are low.
- R2: Register address 0 is the configuration register and address 1 is the data register. Read data appears one cycle after the read strobe. The configuration bits, from bit 7 down to bit 0, are: interrupt enable, enable, LSB-first, master, clock polarity, clock phase, rate bit 1 and rate bit 0.
- R3: In master mode the serial clock period is 4, 8, 32 or 64 system clocks, for rate codes 0, 1, 2 and 3 respectively. Each transfer lasts 8 serial clock periods.
- R4: The master serial clock output rests at the level of the clock polarity bit whenever no transfer is running: high when the bit is 1, low when it is 0.
- R5: With clock phase 0, data is sampled on the leading edge and changed on the trailing edge. With clock phase 1, data is changed on the leading edge and sampled on the trailing edge. A leading edge is the edge that moves the clock away from its resting level.
- R6: With LSB-first set to 1, bit 0 is shifted out and in first. With it set to 0, bit 7 goes first. After the transfer, the received byte sits in the data register in normal bit significance.
- R7: In master mode, writing the data register while enabled and idle starts a transfer. The completion flag rises when the transfer ends and falls when the data register is read.
- R8: The interrupt output is high exactly when the completion flag, the interrupt-enable bit and the serial-interrupt enable input are all 1. It lags them by one cycle.
- R9: In slave mode, a low select frames the transfer, and the slave drives its data output only while the select is low. The rate bits have no effect in slave mode: a serial clock faster than the programmed rate is still followed.
- R10: A slave that is not reloaded between two transfers sends out, in the second transfer, the byte it received in the first.
- R11: A warm reset clears the configuration register and the completion flag, and keeps the data register contents.
- R12: While the enable bit is 0, all pin output enables are low. A data write then loads the register but starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Cold reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high; keeps the data register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 selects configuration, 1 selects data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| ser_int_en | input | 1 | External serial-interrupt enable |
| irq | output | 1 | Gated completion interrupt |
| xfer_done | output | 1 | Completion flag |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Master data in |
| ss_n_i | input | 1 | Slave select in, active low |

## Verification
The echo case is the hardest to reach from the ports. It needs two back-to-back slave frames with no data write between them, and the second frame's output must be compared with the first frame's input after the bit-order reversal that the LSB-first mode applies. The bench drives both frames from a bench-side serial master that runs faster than the programmed rate. That master spaces its edges so that the two-stage synchroniser delay fits inside each half period. A bench-side slave model answers the master transfers. It records the data-out stream and drives the data-in stream at the edges that the phase setting calls for.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } spi_ctrl_t;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int N = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [N];

  for (genvar g = 0; g < N; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign q = st[N-1];
endmodule

// File: rtl/spi_port_sckgen.sv
module spi_port_sckgen #(
  parameter int HW   = 6,
  parameter int NTOG = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [HW-1:0] half,
  output logic          busy,
  output logic          phase,
  output logic          lead,
  output logic          trail
);
  localparam int TW = $clog2(NTOG);

  logic [HW-1:0] hc;
  logic [TW-1:0] tog;
  logic          wrap;

  assign wrap  = busy && (hc == half - 1'b1);
  assign lead  = wrap && !phase;
  assign trail = wrap && phase;

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      busy  <= 1'b0;
      hc    <= '0;
      phase <= 1'b0;
      tog   <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      hc    <= '0;
      phase <= 1'b0;
      tog   <= '0;
    end else if (busy) begin
      if (wrap) begin
        hc    <= '0;
        phase <= ~phase;
        tog   <= tog + 1'b1;
        if (tog == TW'(NTOG - 1)) busy <= 1'b0;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          cold_rst,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  input  logic          lead,
  input  logic          trail,
  input  logic          clear,
  input  logic          lsb_first,
  input  logic          cpha,
  input  logic          rx_bit,
  output logic [DW-1:0] data,
  output logic          tx_bit,
  output logic          done
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sr;
  logic          samp;
  logic          obit;
  logic [CW-1:0] cnt;

  function automatic logic out_of(input logic [DW-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DW-1];
  endfunction

  function automatic logic [DW-1:0] shifted(input logic [DW-1:0] v,
                                            input logic b, input logic lsb);
    return lsb ? {b, v[DW-1:1]} : {v[DW-2:0], b};
  endfunction

  // Data register: only the cold reset clears it.
  always_ff @(posedge clk) begin
    if (cold_rst)   sr <= '0;
    else if (load)  sr <= wdata;
    else if (trail) sr <= shifted(sr, cpha ? rx_bit : samp, lsb_first);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      samp <= 1'b0;
      obit <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load || clear) begin
        cnt <= '0;
      end else begin
        if (lead) begin
          if (!cpha) samp <= rx_bit;
          else       obit <= out_of(sr, lsb_first);
        end
        if (trail) begin
          if (cnt == CW'(DW - 1)) begin
            cnt  <= '0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  assign data   = sr;
  assign tx_bit = cpha ? obit : out_of(sr, lsb_first);
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl #(
  parameter int DIV0   = 4,
  parameter int DIV1   = 8,
  parameter int DIV2   = 32,
  parameter int DIV3   = 64,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       warm_rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ser_int_en,
  output logic       irq,
  output logic       xfer_done,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       miso_i,
  input  logic       ss_n_i
);
  import spi_port_pkg::*;

  localparam int DW   = 8;
  localparam int HW   = $clog2(DIV3 / 2) + 1;
  localparam int NTOG = 2 * DW;

  spi_ctrl_t     ctrl_q;
  logic          soft_rst;
  logic          sck_s, mosi_s, ss_s;
  logic          act, act_d;
  logic          slave_sel;
  logic          s_lead, s_trail;
  logic [HW-1:0] half;
  logic          wr_data, m_start, load;
  logic          m_busy, m_phase, m_lead, m_trail;
  logic [DW-1:0] data;
  logic          tx_bit, done_p;
  logic          flag_q, irq_q;

  assign soft_rst = rst || warm_rst;

  always_ff @(posedge clk) begin
    if (soft_rst)                           ctrl_q <= '0;
    else if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= spi_ctrl_t'(reg_wdata);
  end

  spi_port_sync #(.N(SYNC_N), .W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(soft_rst),
    .d({sck_i, mosi_i, ss_n_i}),
    .q({sck_s, mosi_s, ss_s})
  );

  assign act       = sck_s ^ ctrl_q.cpol;
  assign slave_sel = ctrl_q.enable && !ctrl_q.master && !ss_s;
  assign s_lead    = slave_sel && act && !act_d;
  assign s_trail   = slave_sel && !act && act_d;

  always_ff @(posedge clk) begin
    if (soft_rst) act_d <= 1'b0;
    else          act_d <= act;
  end

  always_comb begin
    case (ctrl_q.rate)
      2'd0:    half = HW'(DIV0 / 2);
      2'd1:    half = HW'(DIV1 / 2);
      2'd2:    half = HW'(DIV2 / 2);
      default: half = HW'(DIV3 / 2);
    endcase
  end

  assign wr_data = reg_wr && reg_addr == ADDR_DATA;
  assign m_start = wr_data && ctrl_q.enable && ctrl_q.master && !m_busy;
  assign load    = wr_data && !m_busy && !slave_sel;

  spi_port_sckgen #(.HW(HW), .NTOG(NTOG)) u_sck (
    .clk(clk), .rst(soft_rst), .start(m_start),
    .stop(!ctrl_q.enable || !ctrl_q.master),
    .half(half), .busy(m_busy), .phase(m_phase),
    .lead(m_lead), .trail(m_trail)
  );

  spi_port_shift #(.DW(DW)) u_shift (
    .clk(clk), .cold_rst(rst), .rst(soft_rst), .load(load), .wdata(reg_wdata),
    .lead(m_lead || s_lead), .trail(m_trail || s_trail),
    .clear(!ctrl_q.enable || (!ctrl_q.master && ss_s)),
    .lsb_first(ctrl_q.lsb_first), .cpha(ctrl_q.cpha),
    .rx_bit(ctrl_q.master ? miso_i : mosi_s),
    .data(data), .tx_bit(tx_bit), .done(done_p)
  );

  always_ff @(posedge clk) begin
    if (soft_rst) begin
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (done_p)                                flag_q <= 1'b1;
      else if (reg_rd && reg_addr == ADDR_DATA)  flag_q <= 1'b0;
      irq_q <= flag_q && ctrl_q.irq_en && ser_int_en;
      if (reg_rd) reg_rdata <= (reg_addr == ADDR_DATA) ? data : 8'(ctrl_q);
    end
  end

  assign xfer_done = flag_q;
  assign irq       = irq_q;
  assign sck_o     = m_phase ^ ctrl_q.cpol;
  assign sck_oe    = ctrl_q.enable && ctrl_q.master;
  assign mosi_o    = tx_bit;
  assign mosi_oe   = ctrl_q.enable && ctrl_q.master;
  assign miso_o    = tx_bit;
  assign miso_oe   = slave_sel;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DIV0 = 4,
  parameter int DIV1 = 8,
  parameter int DIV2 = 32,
  parameter int DIV3 = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    warm_rst,
  input logic                    reg_wr,
  input logic                    reg_addr,
  input logic                    ser_int_en,
  input logic                    irq,
  input logic                    sck_o,
  input logic                    sck_oe,
  input logic                    mosi_oe,
  input logic                    miso_oe,
  input spi_port_pkg::spi_ctrl_t ctrl,
  input logic                    busy
);
  logic [7:0] hcnt;
  logic       sck_prev;
  logic [7:0] exp_half;

  always_comb begin
    case (ctrl.rate)
      2'd0:    exp_half = 8'(DIV0 / 2);
      2'd1:    exp_half = 8'(DIV1 / 2);
      2'd2:    exp_half = 8'(DIV2 / 2);
      default: exp_half = 8'(DIV3 / 2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      hcnt     <= '0;
      sck_prev <= sck_o;
    end else begin
      sck_prev <= sck_o;
      if (sck_o != sck_prev) hcnt <= 8'd1;
      else if (!busy)        hcnt <= '0;
      else                   hcnt <= hcnt + 1'b1;
    end
  end

  // R12
  disabled_pins_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    !ctrl.enable |-> (!sck_oe && !mosi_oe && !miso_oe));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (ctrl.enable && ctrl.master && !busy && !$past(busy)) |-> (sck_o == ctrl.cpol));

  // R3
  half_period_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (ctrl.master && sck_o != sck_prev && hcnt != 0) |-> (hcnt == exp_half));

  // R7
  start_cause_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    $rose(busy) |-> $past(reg_wr && reg_addr));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    !ser_int_en |=> !irq);

  // R9
  slave_drive_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    miso_oe |-> (!sck_oe && !mosi_oe));
endmodule

bind spi_port_ctrl spi_port_chk #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_chk (
  .clk(clk), .rst(rst), .warm_rst(warm_rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ser_int_en(ser_int_en), .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe), .ctrl(ctrl_q), .busy(m_busy)
);

// File: tb/sim_spi_port_ctrl.sv
module sim_spi_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 6;

  logic clk = 0, rst = 1, warm_rst = 0;
  logic reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic ser_int_en = 0;
  logic irq, xfer_done, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;

  spi_port_ctrl u0 (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ser_int_en(ser_int_en), .irq(irq), .xfer_done(xfer_done),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { string tag; logic [7:0] val; } exp_t;
  exp_t sb_q[$];

  task automatic push_exp(input string tag, input logic [7:0] v);
    exp_t e;
    e.tag = tag; e.val = v;
    sb_q.push_back(e);
  endtask

  task automatic mon_cmp(input logic [7:0] act);
    exp_t e;
    checks++;
    if (sb_q.size() == 0) begin
      fails++;
      $display("FAIL scoreboard empty actual=%h expected=none", act);
    end else begin
      e = sb_q.pop_front();
      if (act !== e.val) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", e.tag, act, e.val);
      end
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  // Bench-side slave model answering master transfers
  logic m_on = 0, m_cpol = 0, m_cpha = 0, prev_sck = 0;
  logic [7:0] m_sb = 0, m_cap = 0;
  int nlead = 0, ntrail = 0, t0 = 0, t1 = 0;

  always @(negedge clk) begin
    if (!m_on) begin
      nlead = 0; ntrail = 0; m_cap = 0;
    end else if (sck_o !== prev_sck) begin
      if (sck_o ^ m_cpol) begin
        if (nlead == 0) t0 = cyc;
        if (nlead == 1) t1 = cyc;
        if (!m_cpha) m_cap = {m_cap[6:0], mosi_o};
        else         miso_i = m_sb[7-nlead];
        nlead++;
      end else begin
        if (m_cpha) m_cap = {m_cap[6:0], mosi_o};
        else if (ntrail < 7) miso_i = m_sb[6-ntrail];
        ntrail++;
      end
    end else if (nlead == 0 && ntrail == 0 && !m_cpha) begin
      miso_i = m_sb[7];
    end
    prev_sck = sck_o;
  end

  task automatic m_xfer(input logic [7:0] cfg, input logic [7:0] tx, input logic [7:0] sbyte);
    logic [7:0] d;
    int div;
    bit seen;
    wr(0, (cfg & 8'hBF) | 8'h10);
    wr(0, cfg | 8'h50);
    m_cpol = cfg[3]; m_cpha = cfg[2]; m_sb = sbyte; m_on = 1;
    cyc_wait(2);
    push_exp("R6 mosi stream", cfg[5] ? rev8(tx) : tx);
    push_exp("R5 received byte", cfg[5] ? rev8(sbyte) : sbyte);
    wr(1, tx);
    seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (xfer_done) seen = 1;
    end
    chk("R7 completion flag", int'(seen), 1);
    m_on = 0;
    mon_cmp(m_cap);
    cyc_wait(2);
    chk("R8 irq gate", int'(irq), int'(cfg[7] & ser_int_en));
    chk("R4 idle sck level", int'(sck_o), int'(cfg[3]));
    case (cfg[1:0])
      2'd0: div = 4; 2'd1: div = 8; 2'd2: div = 32; default: div = 64;
    endcase
    chk("R3 sck period", t1 - t0, div);
    rd(1, d);
    mon_cmp(d);
    cyc_wait(2);
    chk("R7 flag cleared by read", int'(xfer_done), 0);
    chk("R8 irq cleared", int'(irq), 0);
  endtask

  // Bench-side master driving a slave-mode block
  task automatic s_xfer(input logic cpol, input logic cpha, input logic [7:0] mb,
                        output logic [7:0] cap);
    cap = 0;
    ss_n_i = 0;
    if (!cpha) mosi_i = mb[7];
    cyc_wait(SH);
    chk("R9 miso driven with select low", int'(miso_oe), 1);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        cap = {cap[6:0], miso_o};
        sck_i = ~cpol;
        cyc_wait(SH);
        sck_i = cpol;
        if (i < 7) mosi_i = mb[6-i];
        cyc_wait(SH);
      end else begin
        sck_i = ~cpol;
        mosi_i = mb[7-i];
        cyc_wait(SH);
        cap = {cap[6:0], miso_o};
        sck_i = cpol;
        cyc_wait(SH);
      end
    end
    cyc_wait(SH);
    ss_n_i = 1;
    cyc_wait(SH);
  endtask

  task automatic slave_run(input logic [7:0] cfg, input logic [7:0] ld,
                           input logic [7:0] mb1, input logic [7:0] mb2);
    logic [7:0] cap, d, got;
    wr(0, cfg & 8'hAF);
    sck_i = cfg[3];
    wr(0, (cfg & 8'hEF) | 8'h40);
    cyc_wait(4);
    chk("R9 miso released with select high", int'(miso_oe), 0);
    wr(1, ld);
    push_exp("R9 slave transmit", cfg[5] ? rev8(ld) : ld);
    s_xfer(cfg[3], cfg[2], mb1, cap);
    mon_cmp(cap);
    chk("R7 slave completion flag", int'(xfer_done), 1);
    push_exp("R9 slave receive", cfg[5] ? rev8(mb1) : mb1);
    rd(1, got);
    mon_cmp(got);
    push_exp("R10 echo", cfg[5] ? rev8(got) : got);
    s_xfer(cfg[3], cfg[2], mb2, cap);
    mon_cmp(cap);
    rd(1, d);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    finish_run();
  end

  initial begin
    logic [7:0] d, keep;
    cyc_wait(4);
    rst = 0;
    cyc_wait(2);
    // R1 reset state
    rd(0, d); chk("R1 ctrl reset", d, 8'h00);
    rd(1, d); chk("R1 data reset", d, 8'h00);
    chk("R1 pins released", int'({sck_oe, mosi_oe, miso_oe, xfer_done, irq}), 0);

    // R2 configuration readback, enable left 0
    wr(0, 8'h3B);
    rd(0, d); chk("R2 ctrl readback", d, 8'h3B);

    // R12 disabled: load but no transfer
    wr(0, 8'h10);
    wr(1, 8'h77);
    cyc_wait(60);
    chk("R12 outputs disabled", int'({sck_oe, mosi_oe, miso_oe}), 0);
    chk("R12 no transfer", int'(xfer_done), 0);
    rd(1, d); chk("R12 data loaded", d, 8'h77);

    // Master transfers over modes and rates
    ser_int_en = 1;
    m_xfer(8'h00, 8'hA5, 8'h3C);
    m_xfer(8'h2F, 8'h81, 8'h6E);
    ser_int_en = 0;
    m_xfer(8'h85, 8'hC3, 8'h5A);
    ser_int_en = 1;
    m_xfer(8'hAA, 8'h1E, 8'hF0);

    // Slave transfers, rate code 3 while driven much faster
    wr(0, 8'h00);
    slave_run(8'h03, 8'h96, 8'h4D, 8'hB2);
    slave_run(8'h2F, 8'h71, 8'hC8, 8'h13);

    // R11 warm reset keeps data
    wr(0, 8'h10);
    wr(1, 8'hE4);
    wr(0, 8'h5B);
    rd(1, keep);
    chk("R11 data before warm reset", keep, 8'hE4);
    @(negedge clk); warm_rst = 1; @(negedge clk); warm_rst = 0;
    rd(0, d); chk("R11 ctrl cleared", d, 8'h00);
    rd(1, d); chk("R11 data kept", d, 8'hE4);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    rd(1, d); chk("R1 cold reset clears data", d, 8'h00);

    chk("scoreboard drained R9", sb_q.size(), 0);
    finish_run();
  end
endmodule